// File: doc/BRIEF.md
# Link Bit-Error Test Checker

This block is the receive-side judge of a serial link in test mode. The far end sends a pseudo-random bit stream, and the link delivers it as parallel words, each marked by a valid strobe. The checker locks a local PRBS7 reference onto the incoming stream and compares every later word against it. It reports the verdict on one active-low status pin: high means no error has been seen, and low means a bit error.

Two link flavours are supported, selected by a single input, so only one can be active at a time. For the main link, a latch-select input chooses the reporting style:

- **Sticky:** the first error holds the pin low.
- **Live:** the pin follows the latest comparison. Dropping latch-select to 0 also clears any held error.

For the sub link, only the sticky report exists. A zero on latch-select is an illegal setting and is reported as an error. A held sub-link error survives leaving and re-entering test mode, and only reset removes it. While test mode is off, the pin rests high and the received words are not examined.

Top module: `lbt_checker`

## Requirements
- R1: While `test_en` is 0, `status_n` is 1 whatever `rx_data`, `rx_valid`, `link_sel` and `latch_sel` carry, and no error is recorded from those words.
- R2: The first word with `rx_valid`=1 after `test_en` rises is never compared. Its seven most recent bits seed the reference, where bit 0 of a word is the earliest bit and bit W-1 the latest. Comparison starts with the next valid word.
- R3: The reference follows b[n] = b[n-6] xor b[n-7], which is PRBS7 with polynomial x^7+x^6+1. A received stream that obeys this rule keeps `status_n` at 1 from any starting phase.
- R4: In main-link mode (`link_sel`=0) with `latch_sel`=1, a compared word with one or more wrong bits drives `status_n` to 0 after the clock edge that takes the word. The pin stays 0 through later correct words.
- R5: In main-link mode with `latch_sel`=0, `status_n` shows the result of the most recently compared word: 0 if that word had an error, 1 if it was correct.
- R6: In main-link mode, one clock edge with `latch_sel`=0 clears a held error. After `latch_sel` returns to 1, `status_n` is 1 until a new error arrives.
- R7: In sub-link mode (`link_sel`=1), errors are always held. The held error stays through `test_en` dropping and rising again and through `latch_sel`=0. Only reset clears it, and while `test_en` is 0 the pin still reads 1 per R1.
- R8: In sub-link mode with `test_en`=1, `latch_sel`=0 is an illegal setting. It records a held error from the next clock edge, even with no word received.
- R9: Cycles with `rx_valid`=0 neither compare nor advance the reference. The stream resumes where it stopped.
- R10: Dropping `test_en` discards the reference lock. The next entry re-seeds from whatever phase of the sequence then arrives, without reporting an error.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low; clears lock and held error |
| test_en | input | 1 | Test mode active |
| link_sel | input | 1 | 0 = main-link rules, 1 = sub-link rules |
| latch_sel | input | 1 | 1 = hold errors, 0 = live report (main) or illegal (sub) |
| rx_valid | input | 1 | `rx_data` carries a word this cycle |
| rx_data | input | W | Received word, bit 0 earliest |
| status_n | output | 1 | 1 = no error, 0 = error detected |

## Verification
A word presented before rising edge k affects `status_n` just after edge k. There is exactly one register between the word and the held or live error state. Changes on `test_en`, `link_sel` or `latch_sel` alter which state the pin shows at once. Their effect on the stored error (a clear or an illegal-setting flag) appears one edge later.

The bench drives every input on the falling edge and samples `status_n` 1 ns after the next rising edge. Each check therefore sees exactly the one edge its stimulus was due to act on. It sweeps all 127 non-zero seed phases and every single-bit error position of an 8-bit word.

// File: rtl/lbt_pkg.sv
package lbt_pkg;
  localparam int PRBS_LEN = 7;

  typedef enum logic {
    LINK_MAIN = 1'b0,
    LINK_SUB  = 1'b1
  } link_sel_e;

  // h[0] is the newest bit, h[6] the oldest kept: b[n] = b[n-6] ^ b[n-7]
  function automatic logic prbs7_fb(input logic [PRBS_LEN-1:0] h);
    return h[5] ^ h[6];
  endfunction
endpackage

// File: rtl/lbt_ref_gen.sv
module lbt_ref_gen
  import lbt_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         test_en,
  input  logic         rx_valid,
  input  logic [W-1:0] rx_data,
  output logic         cmp_en,
  output logic [W-1:0] ref_word
);
  localparam int SL = PRBS_LEN;

  // expected next W bits from history st, bit 0 first
  function automatic logic [W-1:0] pred_word(input logic [SL-1:0] st);
    logic [SL-1:0] h;
    logic [W-1:0]  r;
    h = st;
    for (int i = 0; i < W; i++) begin
      r[i] = prbs7_fb(h);
      h    = {h[SL-2:0], r[i]};
    end
    return r;
  endfunction

  // history after W predicted bits
  function automatic logic [SL-1:0] adv_state(input logic [SL-1:0] st);
    logic [SL-1:0] h;
    logic          b;
    h = st;
    for (int i = 0; i < W; i++) begin
      b = prbs7_fb(h);
      h = {h[SL-2:0], b};
    end
    return h;
  endfunction

  // history taken from the newest seven bits of a received word
  function automatic logic [SL-1:0] seed_state(input logic [W-1:0] d);
    logic [SL-1:0] s;
    for (int k = 0; k < SL; k++) s[k] = d[W-1-k];
    return s;
  endfunction

  logic [SL-1:0] st_q;
  logic          seeded_q;
  logic          seed_load;

  assign seed_load = test_en & rx_valid & ~seeded_q;
  assign cmp_en    = test_en & rx_valid & seeded_q;
  assign ref_word  = pred_word(st_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= '0;
      seeded_q <= 1'b0;
    end else if (!test_en) begin
      seeded_q <= 1'b0;
    end else if (seed_load) begin
      st_q     <= seed_state(rx_data);
      seeded_q <= 1'b1;
    end else if (cmp_en) begin
      st_q     <= adv_state(st_q);
    end
  end

  assert_unlock_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !test_en |=> !seeded_q);
  assert_seed_R2: assert property (@(posedge clk) disable iff (!rst_n)
    seed_load |=> seeded_q);
  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (test_en && !rx_valid && seeded_q) |=> $stable(st_q));
endmodule

// File: rtl/lbt_cmp.sv
module lbt_cmp #(
  parameter int W = 8
) (
  input  logic [W-1:0] rx_data,
  input  logic [W-1:0] ref_word,
  input  logic         cmp_en,
  output logic         mismatch
);
  logic [W-1:0] diff;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign diff[i] = rx_data[i] ^ ref_word[i];
  end

  assign mismatch = cmp_en & (|diff);
endmodule

// File: rtl/lbt_verdict.sv
module lbt_verdict
  import lbt_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic test_en,
  input  logic link_sel,
  input  logic latch_sel,
  input  logic cmp_en,
  input  logic mismatch,
  output logic status_n
);
  logic sub_mode;
  logic clr_evt;
  logic forbid_evt;
  logic set_evt;
  logic sticky_q;
  logic live_q;

  assign sub_mode   = (link_sel == LINK_SUB);
  assign clr_evt    = test_en & ~sub_mode & ~latch_sel;
  assign forbid_evt = test_en & sub_mode & ~latch_sel;
  assign set_evt    = mismatch | forbid_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sticky_q <= 1'b0;
      live_q   <= 1'b0;
    end else begin
      if (clr_evt)      sticky_q <= 1'b0;
      else if (set_evt) sticky_q <= 1'b1;
      if (!test_en)     live_q   <= 1'b0;
      else if (cmp_en)  live_q   <= mismatch;
    end
  end

  always_comb begin
    if (!test_en)                   status_n = 1'b1;
    else if (sub_mode || latch_sel) status_n = ~sticky_q;
    else                            status_n = ~live_q;
  end

  assert_sub_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sticky_q && sub_mode) |=> sticky_q);
  assert_latch_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mismatch && !clr_evt) |=> sticky_q);
  assert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    clr_evt |=> !sticky_q);
  assert_forbid_R8: assert property (@(posedge clk) disable iff (!rst_n)
    forbid_evt |=> sticky_q);
  assert_live_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_en |=> (live_q == $past(mismatch)));
endmodule

// File: rtl/lbt_checker.sv
module lbt_checker #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         test_en,
  input  logic         link_sel,
  input  logic         latch_sel,
  input  logic         rx_valid,
  input  logic [W-1:0] rx_data,
  output logic         status_n
);
  logic         cmp_en;
  logic         mismatch;
  logic [W-1:0] ref_word;

  lbt_ref_gen #(.W(W)) u_ref (
    .clk      (clk),
    .rst_n    (rst_n),
    .test_en  (test_en),
    .rx_valid (rx_valid),
    .rx_data  (rx_data),
    .cmp_en   (cmp_en),
    .ref_word (ref_word)
  );

  lbt_cmp #(.W(W)) u_cmp (
    .rx_data  (rx_data),
    .ref_word (ref_word),
    .cmp_en   (cmp_en),
    .mismatch (mismatch)
  );

  lbt_verdict u_vrd (
    .clk       (clk),
    .rst_n     (rst_n),
    .test_en   (test_en),
    .link_sel  (link_sel),
    .latch_sel (latch_sel),
    .cmp_en    (cmp_en),
    .mismatch  (mismatch),
    .status_n  (status_n)
  );
endmodule

// File: tb/sim_lbt_checker.sv
`timescale 1ns/1ps
module sim_lbt_checker;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         test_en = 1'b0;
  logic         link_sel = 1'b0;
  logic         latch_sel = 1'b1;
  logic         rx_valid = 1'b0;
  logic [W-1:0] rx_data = '0;
  logic         status_n;

  int n_run = 0;
  int n_fail = 0;
  logic [6:0] sr;   // bench generator: sr[0] oldest bit, sr[6] newest

  always #4 clk = ~clk;

  lbt_checker #(.W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .test_en(test_en), .link_sel(link_sel),
    .latch_sel(latch_sel), .rx_valid(rx_valid), .rx_data(rx_data),
    .status_n(status_n)
  );

  task automatic chk(input string req, input logic exp);
    n_run++;
    if (status_n !== exp) begin
      n_fail++;
      $display("FAIL %s: status_n actual=%b expected=%b at %0t", req, status_n, exp, $time);
    end
  endtask

  // next stream word from the bench generator, bit 0 first
  task automatic gen(output logic [W-1:0] w);
    logic nb;
    for (int i = 0; i < W; i++) begin
      nb = sr[0] ^ sr[1];
      sr = {nb, sr[6:1]};
      w[i] = nb;
    end
  endtask

  task automatic put(input logic [W-1:0] d, input logic v);
    @(negedge clk);
    rx_data = d; rx_valid = v;
    @(posedge clk); #1;
  endtask

  task automatic good(input string req, input int n);
    logic [W-1:0] w;
    for (int k = 0; k < n; k++) begin
      gen(w); put(w, 1'b1); chk(req, 1'b1);
    end
  endtask

  task automatic set_ctl(input logic te, input logic ls, input logic lt);
    @(negedge clk);
    test_en = te; link_sel = ls; latch_sel = lt; rx_valid = 1'b0;
    @(posedge clk); #1;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; test_en = 1'b0; rx_valid = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
  endtask

  // leave and re-enter test mode, then send the seed word
  task automatic reseed(input logic [6:0] s, input logic ls, input logic lt);
    logic [W-1:0] w;
    set_ctl(1'b0, ls, lt);
    set_ctl(1'b1, ls, lt);
    sr = s;
    gen(w); put(w, 1'b1);
  endtask

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [W-1:0] w;
    do_reset();
    chk("R1 reset", 1'b1);

    // R1: test mode off, garbage ignored
    for (int k = 0; k < 4; k++) begin
      put(8'hA5 ^ W'(k * 37), 1'b1); chk("R1 idle", 1'b1);
    end
    set_ctl(1'b0, 1'b1, 1'b0); chk("R1 idle sub illegal", 1'b1);

    // R2/R3/R10: every seed phase, main latched
    for (int s = 1; s < 128; s++) begin
      set_ctl(1'b0, 1'b0, 1'b1);
      set_ctl(1'b1, 1'b0, 1'b1);
      put(W'(s * 29 + 3), 1'b1);       // arbitrary seed word
      chk("R2 seed no compare", 1'b1);
      reseed(7'(s), 1'b0, 1'b1);
      chk("R10 reseed", 1'b1);
      good("R3 clean stream", 3);
    end

    // R9: invalid cycles do not advance the reference
    reseed(7'h2B, 1'b0, 1'b1);
    good("R9 before gap", 2);
    put(8'hFF, 1'b0); chk("R9 gap", 1'b1);
    put(8'h00, 1'b0); chk("R9 gap", 1'b1);
    good("R9 after gap", 3);

    // R4/R6: error at every bit position, latched then cleared
    for (int p = 0; p < W; p++) begin
      reseed(7'h55, 1'b0, 1'b1);
      good("R4 pre", 2);
      gen(w); put(w ^ (W'(1) << p), 1'b1); chk("R4 error latched", 1'b0);
      gen(w); put(w, 1'b1); chk("R4 held after good", 1'b0);
      gen(w); put(w, 1'b1); chk("R4 held after good", 1'b0);
      set_ctl(1'b1, 1'b0, 1'b0); chk("R6 clear shows live", 1'b1);
      set_ctl(1'b1, 1'b0, 1'b1); chk("R6 cleared", 1'b1);
      good("R6 after clear", 1);
    end

    // R5: live reporting
    reseed(7'h11, 1'b0, 1'b0);
    for (int p = 0; p < W; p++) begin
      gen(w); put(w ^ (W'(1) << p), 1'b1); chk("R5 live error", 1'b0);
      gen(w); put(w, 1'b1); chk("R5 live good", 1'b1);
    end

    // R7: sub link always holds, survives test exit, reset clears
    do_reset();
    reseed(7'h3C, 1'b1, 1'b1);
    good("R7 sub clean", 2);
    gen(w); put(w ^ W'(8'h10), 1'b1); chk("R7 sub error", 1'b0);
    gen(w); put(w, 1'b1); chk("R7 sub held", 1'b0);
    set_ctl(1'b0, 1'b1, 1'b1); chk("R1 sub idle high", 1'b1);
    set_ctl(1'b1, 1'b1, 1'b1); chk("R7 held after reentry", 1'b0);
    set_ctl(1'b1, 1'b1, 1'b0); chk("R7 latch_sel no clear", 1'b0);
    do_reset();
    reseed(7'h3C, 1'b1, 1'b1);
    chk("R7 reset cleared", 1'b1);
    good("R7 after reset", 2);

    // R8: illegal latch setting in sub mode
    do_reset();
    set_ctl(1'b1, 1'b1, 1'b0); chk("R8 illegal flagged", 1'b0);
    set_ctl(1'b1, 1'b1, 1'b1); chk("R8 stays flagged", 1'b0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule